// File: doc/BRIEF.md
# Aperture Page Remapping Table

This block turns device addresses that land inside a fixed, page-aligned window into physical addresses. The window starts at a parameterised base and spans a parameterised number of 4 KiB pages. Each page has one 32-bit slot in an on-chip table. A slot holds a valid flag in bit 31 and a physical page frame in bits 30:12.

Software fills the table through a three-register window on a simple register bus. First it writes a byte address from inside the window into the slot-pointer register. It then writes or reads the slot through the slot-data register. A control register switches translation on and off.

A separate lookup port takes one address per cycle. One cycle later it returns the result with exactly one of three flags set:
- hit: the translated address.
- fault: a mapped-out page inside the window; the address output is zero.
- miss: the input address passed through unchanged, because translation is off or the address lies outside the window.

Two state machines run the block. The control machine has the states CTRL_OFF and CTRL_ON. A control write with bit 0 set takes CTRL_OFF to CTRL_ON, a control write with bit 0 clear takes CTRL_ON back to CTRL_OFF, and every other cycle keeps the current state. The lookup machine has the states XS_IDLE and XS_RESP. A request in any cycle moves it to XS_RESP, where the response is presented. A cycle without a request returns it to XS_IDLE.

Top module: `aperture_remap`

## Requirements
- R1: After reset, translation is disabled, every table slot is zero, the slot pointer is zero, and reg_rvalid, reg_rdata, xl_valid, xl_out and the three flags are zero.
- R2: Register offsets on reg_addr are: 0x0 control (reads back 31 zero bits above the enable bit), 0x4 slot pointer (reads back the full 32-bit value written), and 0x8 slot data. Any other offset reads zero. Read data and reg_rvalid appear in the cycle after the reg_rd strobe.
- R3: A write to offset 0x8 stores all 32 bits into the slot numbered (pointer − base) >> 12. A read of 0x8 returns that stored word, bit 31 included.
- R4: While the pointer lies outside [base, base + pages×4096 − 1], writes to 0x8 leave every slot unchanged and reads of 0x8 return zero.
- R5: A lookup is a hit when translation is enabled, the address is inside the window, and the selected slot has bit 31 set. One cycle after the request, xl_hit is 1 and xl_out is {1'b0, slot[30:12], addr[11:0]}. Slot bits 11:0 do not affect the result.
- R6: A lookup inside the window with translation enabled, where the selected slot has bit 31 clear, gives xl_fault = 1 and xl_out = 0 one cycle after the request.
- R7: A lookup made while translation is disabled, or to an address below the base or at or above base + pages×4096, gives xl_miss = 1 and xl_out equal to the requested address one cycle after the request.
- R8: xl_valid is 1 exactly in the cycle after a request, and then exactly one flag is set. In a cycle with no response, the flags and xl_out are all zero.
- R9: Writing zero to a slot unmaps its page, so later lookups to that page fault.
- R10: A write to the control register enables translation when bit 0 is 1 and disables it when bit 0 is 0, taking effect for requests made from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| xl_req | input | 1 | Lookup request |
| xl_addr | input | 32 | Device address to translate |
| xl_valid | output | 1 | Lookup response valid |
| xl_out | output | 32 | Translated or passed-through address |
| xl_hit | output | 1 | Translated through a valid slot |
| xl_miss | output | 1 | Passed through (disabled or outside the window) |
| xl_fault | output | 1 | Inside the window but slot invalid |

## Verification
The bench builds the block with eight pages at base 0x5800_0000. At that size it can write, read back and look up every slot, and it can probe several offsets within each page. The small window puts both edges of the aperture within reach, so the bench covers the last byte below the base, the base itself, the final byte of the last page and the first byte past the end. It also points the slot pointer outside the window on both sides and confirms afterwards that the table is untouched.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int PAGE_SHIFT = 12;
    localparam int VALID_BIT  = 31;

    localparam logic [3:0] OFF_CTRL  = 4'h0;
    localparam logic [3:0] OFF_SLOT  = 4'h4;
    localparam logic [3:0] OFF_ENTRY = 4'h8;

    typedef enum logic { CTRL_OFF, CTRL_ON } ctrl_state_t;
    typedef enum logic { XS_IDLE, XS_RESP } xl_state_t;
    typedef enum logic [1:0] { RES_NONE, RES_HIT, RES_MISS, RES_FAULT } xl_result_t;

    function automatic logic in_window(logic [31:0] a, logic [32:0] lo, logic [32:0] hi_excl);
        return ({1'b0, a} >= lo) && ({1'b0, a} < hi_excl);
    endfunction

endpackage

// File: rtl/remap_table.sv
module remap_table #(
    parameter int PAGE_COUNT = 32,
    parameter int IDX_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] a_idx,
    output logic [31:0]      a_data,
    input  logic [IDX_W-1:0] b_idx,
    output logic [31:0]      b_data
);

    logic [31:0] slot_q [PAGE_COUNT];

    for (genvar g = 0; g < PAGE_COUNT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        a_data = '0;
        b_data = '0;
        if (int'(a_idx) < PAGE_COUNT) a_data = slot_q[a_idx];
        if (int'(b_idx) < PAGE_COUNT) b_data = slot_q[b_idx];
    end

    // R4: the decoder never issues a write to a slot that does not exist
    a_r4_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < PAGE_COUNT));

endmodule

// File: rtl/remap_regs.sv
module remap_regs
    import remap_pkg::*;
#(
    parameter logic [31:0] APERTURE_BASE = 32'h4000_0000,
    parameter int          PAGE_COUNT    = 32,
    parameter int          IDX_W         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             reg_rvalid,
    output logic             xl_enable,
    output logic             tbl_wr_en,
    output logic [IDX_W-1:0] tbl_wr_idx,
    output logic [31:0]      tbl_wr_data,
    output logic [IDX_W-1:0] tbl_rd_idx,
    input  logic [31:0]      tbl_rd_data
);

    localparam logic [32:0] AP_LO = {1'b0, APERTURE_BASE};
    localparam logic [32:0] AP_HI = AP_LO + 33'(PAGE_COUNT) * 33'd4096;

    ctrl_state_t state_q, state_d;
    logic [31:0] slot_ptr_q;
    logic        slot_in_ap;
    logic [IDX_W-1:0] slot_idx;
    logic        ctrl_wr;
    logic [31:0] rd_mux;

    assign ctrl_wr = reg_wr && (reg_addr == OFF_CTRL);

    // control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTRL_OFF;
        else        state_q <= state_d;
    end

    // control transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTRL_OFF: if (ctrl_wr && reg_wdata[0])  state_d = CTRL_ON;
            CTRL_ON:  if (ctrl_wr && !reg_wdata[0]) state_d = CTRL_OFF;
            default:  state_d = CTRL_OFF;
        endcase
    end

    assign xl_enable = (state_q == CTRL_ON);

    // slot pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_ptr_q <= '0;
        else if (reg_wr && (reg_addr == OFF_SLOT)) slot_ptr_q <= reg_wdata;
    end

    assign slot_in_ap = in_window(slot_ptr_q, AP_LO, AP_HI);
    assign slot_idx   = slot_in_ap ? IDX_W'((slot_ptr_q - APERTURE_BASE) >> PAGE_SHIFT) : '0;

    assign tbl_wr_en   = reg_wr && (reg_addr == OFF_ENTRY) && slot_in_ap;
    assign tbl_wr_idx  = slot_idx;
    assign tbl_wr_data = reg_wdata;
    assign tbl_rd_idx  = slot_idx;

    // read mux
    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            OFF_CTRL:  rd_mux = {31'b0, xl_enable};
            OFF_SLOT:  rd_mux = slot_ptr_q;
            OFF_ENTRY: rd_mux = slot_in_ap ? tbl_rd_data : '0;
            default:   rd_mux = '0;
        endcase
    end

    // registered read response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            reg_rdata  <= reg_rd ? rd_mux : '0;
        end
    end

    // R10: enable follows bit 0 of the last control write
    a_r10_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (xl_enable == $past(reg_wdata[0])));
    // R2: read response one cycle after strobe
    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    // R4: slot data reads outside the window return zero
    a_r4_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == OFF_ENTRY) && !slot_in_ap) |=> (reg_rdata == 32'h0));

endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
    import remap_pkg::*;
#(
    parameter logic [31:0] APERTURE_BASE = 32'h4000_0000,
    parameter int          PAGE_COUNT    = 32,
    parameter int          IDX_W         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             xl_req,
    input  logic [31:0]      xl_addr,
    output logic [IDX_W-1:0] tbl_idx,
    input  logic [31:0]      tbl_data,
    output logic             xl_valid,
    output logic [31:0]      xl_out,
    output logic             xl_hit,
    output logic             xl_miss,
    output logic             xl_fault
);

    localparam logic [32:0] AP_LO = {1'b0, APERTURE_BASE};
    localparam logic [32:0] AP_HI = AP_LO + 33'(PAGE_COUNT) * 33'd4096;

    xl_state_t  state_q, state_d;
    xl_result_t res_d, res_q;
    logic [31:0] out_d, out_q;
    logic        addr_in_ap;
    logic        unused_low;

    assign unused_low = ^tbl_data[PAGE_SHIFT-1:0];

    assign addr_in_ap = in_window(xl_addr, AP_LO, AP_HI);
    assign tbl_idx    = addr_in_ap ? IDX_W'((xl_addr - APERTURE_BASE) >> PAGE_SHIFT) : '0;

    // lookup state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: state_d = xl_req ? XS_RESP : XS_IDLE;
            XS_RESP: state_d = xl_req ? XS_RESP : XS_IDLE;
            default: state_d = XS_IDLE;
        endcase
    end

    // classify the request
    always_comb begin
        if (!enable || !addr_in_ap) begin
            res_d = RES_MISS;
            out_d = xl_addr;
        end else if (tbl_data[VALID_BIT]) begin
            res_d = RES_HIT;
            out_d = {1'b0, tbl_data[30:PAGE_SHIFT], xl_addr[PAGE_SHIFT-1:0]};
        end else begin
            res_d = RES_FAULT;
            out_d = '0;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_NONE;
            out_q <= '0;
        end else if (xl_req) begin
            res_q <= res_d;
            out_q <= out_d;
        end else begin
            res_q <= RES_NONE;
            out_q <= '0;
        end
    end

    assign xl_valid = (state_q == XS_RESP);
    assign xl_out   = out_q;
    assign xl_hit   = xl_valid && (res_q == RES_HIT);
    assign xl_miss  = xl_valid && (res_q == RES_MISS);
    assign xl_fault = xl_valid && (res_q == RES_FAULT);

    // R8: one flag with every response
    a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |-> $onehot({xl_hit, xl_miss, xl_fault}));
    // R8: quiet when no response
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_valid |-> (!(xl_hit || xl_miss || xl_fault) && (xl_out == 32'h0)));
    // R8: response follows request
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> xl_valid);
    // R7: disabled lookups pass through
    a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !enable) |=> (xl_miss && (xl_out == $past(xl_addr))));
    // R6: faults carry a zero address
    a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> (xl_out == 32'h0));
    // R5: hits keep the page offset
    a_r5_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> (!xl_hit || (xl_out[11:0] == $past(xl_addr[11:0]))));

endmodule

// File: rtl/aperture_remap.sv
module aperture_remap #(
    parameter logic [31:0] APERTURE_BASE = 32'h4000_0000,
    parameter int          PAGE_COUNT    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rvalid,
    input  logic        xl_req,
    input  logic [31:0] xl_addr,
    output logic        xl_valid,
    output logic [31:0] xl_out,
    output logic        xl_hit,
    output logic        xl_miss,
    output logic        xl_fault
);

    localparam int IDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;

    logic             enable;
    logic             tbl_wr_en;
    logic [IDX_W-1:0] tbl_wr_idx;
    logic [31:0]      tbl_wr_data;
    logic [IDX_W-1:0] tbl_a_idx;
    logic [31:0]      tbl_a_data;
    logic [IDX_W-1:0] tbl_b_idx;
    logic [31:0]      tbl_b_data;

    remap_regs #(
        .APERTURE_BASE(APERTURE_BASE),
        .PAGE_COUNT   (PAGE_COUNT),
        .IDX_W        (IDX_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .xl_enable  (enable),
        .tbl_wr_en  (tbl_wr_en),
        .tbl_wr_idx (tbl_wr_idx),
        .tbl_wr_data(tbl_wr_data),
        .tbl_rd_idx (tbl_a_idx),
        .tbl_rd_data(tbl_a_data)
    );

    remap_table #(
        .PAGE_COUNT(PAGE_COUNT),
        .IDX_W     (IDX_W)
    ) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr_en),
        .wr_idx (tbl_wr_idx),
        .wr_data(tbl_wr_data),
        .a_idx  (tbl_a_idx),
        .a_data (tbl_a_data),
        .b_idx  (tbl_b_idx),
        .b_data (tbl_b_data)
    );

    remap_xlate #(
        .APERTURE_BASE(APERTURE_BASE),
        .PAGE_COUNT   (PAGE_COUNT),
        .IDX_W        (IDX_W)
    ) xlate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .xl_req  (xl_req),
        .xl_addr (xl_addr),
        .tbl_idx (tbl_b_idx),
        .tbl_data(tbl_b_data),
        .xl_valid(xl_valid),
        .xl_out  (xl_out),
        .xl_hit  (xl_hit),
        .xl_miss (xl_miss),
        .xl_fault(xl_fault)
    );

endmodule

// File: tb/aperture_remap_tb.sv
module aperture_remap_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h5800_0000;
    localparam int          PAGES      = 8;
    localparam logic [31:0] AP_END     = BASE + PAGES * 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        xl_req = 1'b0;
    logic [31:0] xl_addr = '0;
    logic        xl_valid;
    logic [31:0] xl_out;
    logic        xl_hit;
    logic        xl_miss;
    logic        xl_fault;

    int vectors = 0;
    int errors  = 0;
    logic [31:0] shadow [PAGES];

    always #(CLK_PERIOD / 2) clk = ~clk;

    aperture_remap #(.APERTURE_BASE(BASE), .PAGE_COUNT(PAGES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .xl_req(xl_req), .xl_addr(xl_addr), .xl_valid(xl_valid),
        .xl_out(xl_out), .xl_hit(xl_hit), .xl_miss(xl_miss), .xl_fault(xl_fault)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [3:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = off;
        @(negedge clk);
        reg_rd = 1'b0;
        if (reg_rvalid !== 1'b1) begin
            vectors++; errors++;
            $display("FAIL R2: rvalid got %0b expected 1", reg_rvalid);
        end
        d = reg_rdata;
    endtask

    task automatic lookup(input logic [31:0] a, output logic [31:0] o, output logic [3:0] f);
        @(negedge clk);
        xl_req = 1'b1; xl_addr = a;
        @(negedge clk);
        xl_req = 1'b0;
        o = xl_out;
        f = {xl_valid, xl_hit, xl_miss, xl_fault};
    endtask

    // flags: {valid, hit, miss, fault}
    task automatic expect_lookup(input string tag, input logic [31:0] a);
        logic [31:0] o;
        logic [3:0]  f;
        logic [31:0] eo;
        logic [3:0]  ef;
        int pg;
        lookup(a, o, f);
        if (!dut_en_model || a < BASE || a >= AP_END) begin
            eo = a; ef = 4'b1010;
        end else begin
            pg = int'((a - BASE) >> 12);
            if (shadow[pg][31]) begin
                eo = {1'b0, shadow[pg][30:12], a[11:0]}; ef = 4'b1100;
            end else begin
                eo = '0; ef = 4'b1001;
            end
        end
        check({tag, " addr"}, o, eo);
        check({tag, " flags R8"}, {28'b0, f}, {28'b0, ef});
    endtask

    logic dut_en_model = 1'b0;

    task automatic set_enable(input logic en);
        reg_write(4'h0, {31'b0, en});
        dut_en_model = en;
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vectors++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] o;
        logic [3:0]  f;
        for (int i = 0; i < PAGES; i++) shadow[i] = '0;

        repeat (3) @(negedge clk);
        // R1: reset state of outputs
        check("R1 rvalid", {31'b0, reg_rvalid}, 32'h0);
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 xl_out", xl_out, 32'h0);
        check("R1 flags", {28'b0, xl_valid, xl_hit, xl_miss, xl_fault}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle rvalid", {31'b0, reg_rvalid}, 32'h0);

        reg_read(4'h0, d); check("R1 ctrl disabled", d, 32'h0);
        reg_read(4'h4, d); check("R1 pointer zero", d, 32'h0);
        for (int i = 0; i < PAGES; i++) begin
            reg_write(4'h4, BASE + i * 4096);
            reg_read(4'h8, d); check("R1 slot zero", d, 32'h0);
        end

        // R2: other offsets read zero, pointer reads back
        reg_read(4'hC, d); check("R2 unknown offset", d, 32'h0);
        reg_write(4'h4, 32'hDEAD_BEEF);
        reg_read(4'h4, d); check("R2 pointer readback", d, 32'hDEAD_BEEF);

        // R3: fill every slot, low bits stored too
        for (int i = 0; i < PAGES; i++) begin
            shadow[i] = 32'h8000_0000 | (32'(i * 7 + 3) << 12) | 32'h0000_0ABC;
            reg_write(4'h4, BASE + i * 4096 + 32'h123);
            reg_write(4'h8, shadow[i]);
        end
        for (int i = 0; i < PAGES; i++) begin
            reg_write(4'h4, BASE + i * 4096 + 32'hFFF);
            reg_read(4'h8, d); check("R3 slot readback", d, shadow[i]);
        end

        // R7 / R10: disabled lookups pass through
        for (int i = 0; i < PAGES; i++) expect_lookup("R7 disabled", BASE + i * 4096 + 32'h40);

        set_enable(1'b1);
        reg_read(4'h0, d); check("R10 ctrl on", d, 32'h1);

        // R5: sweep every page at several offsets
        for (int i = 0; i < PAGES; i++) begin
            expect_lookup("R5 hit lo", BASE + i * 4096);
            expect_lookup("R5 hit mid", BASE + i * 4096 + 32'h7FF);
            expect_lookup("R5 hit hi", BASE + i * 4096 + 32'hFFF);
        end

        // R7: window edges
        expect_lookup("R7 below base", BASE - 1);
        expect_lookup("R5 first byte", BASE);
        expect_lookup("R5 last byte", AP_END - 1);
        expect_lookup("R7 past end", AP_END);
        expect_lookup("R7 far away", 32'h0000_1000);

        // R8: no response without request
        @(negedge clk);
        check("R8 quiet", {28'b0, xl_valid, xl_hit, xl_miss, xl_fault}, 32'h0);
        check("R8 quiet out", xl_out, 32'h0);

        // R9: unmap even pages; R6: frame set but bit 31 clear
        for (int i = 0; i < PAGES; i += 2) begin
            reg_write(4'h4, BASE + i * 4096);
            reg_write(4'h8, 32'h0);
            shadow[i] = '0;
        end
        reg_write(4'h4, BASE + 1 * 4096);
        reg_write(4'h8, 32'h0001_2000);
        shadow[1] = 32'h0001_2000;
        for (int i = 0; i < PAGES; i++) expect_lookup("R9 R6 after unmap", BASE + i * 4096 + 32'h10);

        // R4: pointer outside the window on both sides
        reg_write(4'h4, AP_END);
        reg_write(4'h8, 32'hFFFF_FFFF);
        reg_read(4'h8, d); check("R4 read past end", d, 32'h0);
        reg_write(4'h4, BASE - 32'h4);
        reg_write(4'h8, 32'hFFFF_FFFF);
        reg_read(4'h8, d); check("R4 read below base", d, 32'h0);
        for (int i = 0; i < PAGES; i++) begin
            reg_write(4'h4, BASE + i * 4096);
            reg_read(4'h8, d); check("R4 slot untouched", d, shadow[i]);
        end

        // R10: disable again
        set_enable(1'b0);
        reg_read(4'h0, d); check("R10 ctrl off", d, 32'h0);
        expect_lookup("R10 disabled miss", BASE + 3 * 4096 + 32'h5);

        // back-to-back lookups
        set_enable(1'b1);
        @(negedge clk);
        xl_req = 1'b1; xl_addr = BASE + 3 * 4096 + 32'hABC;
        @(negedge clk);
        xl_addr = BASE + 7 * 4096 + 32'h001;
        check("R5 b2b first", xl_out, {1'b0, shadow[3][30:12], 12'hABC});
        @(negedge clk);
        xl_req = 1'b0;
        check("R5 b2b second", xl_out, {1'b0, shadow[7][30:12], 12'h001});
        lookup(BASE + 7 * 4096, o, f);
        check("R8 b2b flags", {28'b0, f}, 32'hC);

        finish_run();
    end

endmodule